// File: doc/BRIEF.md
# Two-Stage Watchdog Timer With Registers

This block is a watchdog for a chipset. Software sets a timeout in ticks and must write the reload register before the countdown runs out. An internal prescaler derives the tick from the system clock. The countdown starts again from the programmed value each time the reload register is written.

When the countdown runs out the first time, the block records it in status-1 and can send a one-cycle SMI request. The counter then reloads and keeps running. A second expiry in a row sets the second-timeout and boot-status flags. It also raises a sticky reboot request, unless the speaker strap or the no-reboot input holds the request back.

The block also has a sticky lock bit, a readback of the ticks remaining, and two mailbox bytes. A write to either mailbox byte sets a status flag. Software reaches every register through a little-endian window of byte and word accesses.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, word reads return: 0x00 reload 0x0000, 0x02 data 0x0000, 0x04 status-1 0x0000, 0x06 status-2 0x0000, 0x08 control-1 0x0000, 0x0A control-2 0x0008, 0x0C message 0x0000, 0x0E watchdog-count 0x0000, 0x10 software-IRQ-generate 0x0003, 0x12 timer 0x0004. The countdown is idle after reset.
- R2: A write to the reload register starts the countdown only when control-1 bit 11 (halt) is clear and the low 10 bits of the timer register are greater than 1. With a value of 0 or 1, no countdown starts and no timeout ever occurs.
- R3: After a start with value N, status-1 bit 3 (timeout) sets on the clock edge exactly N*TICK_DIV cycles after the starting edge. The counter then reloads from the timer and keeps counting, so the next expiry comes N*TICK_DIV cycles later.
- R4: On each expiry, smi_req pulses high for one cycle if smi_enable is high, and stays low if smi_enable is low.
- R5: On the second expiry in a row, status-2 bit 1 (second timeout) and bit 2 (boot status) set. If strap_hold and no_reboot are both low, reboot_req goes high and only reset clears it.
- R6: If strap_hold or no_reboot is high at the second expiry, reboot_req stays low. The status-2 bits still set.
- R7: Control-1 bit 12 (lock) can be set but never cleared by a write. While bit 11 (halt) is set, the countdown holds its value. A control-1 write that leaves the timer startable restarts the countdown from the timer value.
- R8: While the countdown runs, a read of the reload register returns the remaining ticks in bits [9:0] and bits [15:10] of the timer value loaded at the last start. When idle, the read returns the stored value.
- R9: A write to byte 0x02 (data-in) sets status-1 bit 1. A write to byte 0x03 (data-out) sets status-1 bit 2. Both bytes keep the written data.
- R10: Status-1 writes keep only bits [3:1], status-2 writes keep only bits [2:1], and control-1 writes keep only bits 12:11. Watchdog-count and software-IRQ-generate keep 8 bits. A byte access at an odd address reaches the upper byte of its 16-bit register.
- R11: A reload write clears the count of consecutive expiries. The next expiry after a reload counts as a first expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 16-bit access (address bit 0 ignored), 0 = byte access |
| acc_addr | input | 5 | Byte address inside the register window |
| acc_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| acc_rdata | output | 16 | Read data, combinational; a byte read returns its byte in bits [7:0] |
| smi_enable | input | 1 | Allows SMI requests on expiry |
| strap_hold | input | 1 | Speaker strap; high blocks the reboot request |
| no_reboot | input | 1 | High blocks the reboot request |
| smi_req | output | 1 | One-cycle SMI request on expiry |
| reboot_req | output | 1 | Sticky reboot request |

## Verification
The assertions assume that smi_enable, strap_hold and no_reboot are level inputs that change only between accesses. They also assume that at most one register access arrives per cycle. The bench sets these inputs before it starts each countdown and holds them until the run's checks are done. It also resets the block between random runs, so each countdown begins from a known idle state with a restarted prescaler.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;

    parameter int CNT_W  = 10;
    parameter int ADDR_W = 5;
    parameter int NREG   = 10;

    // word index = byte address [4:1]
    localparam int W_RLD   = 0;
    localparam int W_DATA  = 1;
    localparam int W_STS1  = 2;
    localparam int W_STS2  = 3;
    localparam int W_CNT1  = 4;
    localparam int W_CNT2  = 5;
    localparam int W_MSG   = 6;
    localparam int W_WDCNT = 7;
    localparam int W_SWIRQ = 8;
    localparam int W_TMR   = 9;

    localparam int S1_SWSMI   = 1;
    localparam int S1_INT     = 2;
    localparam int S1_TIMEOUT = 3;
    localparam int S2_SECOND  = 1;
    localparam int S2_BOOT    = 2;
    localparam int C1_HALT    = 11;
    localparam int C1_LOCK    = 12;

    localparam logic [15:0] STS1_MASK = 16'h000E;
    localparam logic [15:0] STS2_MASK = 16'h0006;
    localparam logic [15:0] CNT1_MASK = 16'h1800;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
    } bus_req_t;

    // Reset value of the plainly stored registers.
    function automatic logic [15:0] plain_default(int idx);
        case (idx)
            W_CNT2:  return 16'h0008;
            W_SWIRQ: return 16'h0003;
            W_TMR:   return 16'h0004;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] plain_mask(int idx);
        case (idx)
            W_WDCNT, W_SWIRQ: return 16'h00FF;
            default:          return 16'hFFFF;
        endcase
    endfunction

    function automatic logic is_plain(int idx);
        return idx == W_DATA || idx == W_CNT2 || idx == W_MSG ||
               idx == W_WDCNT || idx == W_SWIRQ || idx == W_TMR;
    endfunction

    // Byte lanes of register idx written by this request.
    function automatic logic [1:0] lanes(bus_req_t r, int idx);
        if (!r.valid || !r.write || r.addr[ADDR_W-1:1] != 4'(idx))
            return 2'b00;
        if (r.word)
            return 2'b11;
        return r.addr[0] ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [15:0] merge16(logic [15:0] old, logic [1:0] be,
                                            logic [7:0] lo, logic [7:0] hi);
        logic [15:0] v;
        v = old;
        if (be[0]) v[7:0]  = lo;
        if (be[1]) v[15:8] = hi;
        return v;
    endfunction

    function automatic logic can_start(logic halt, logic [CNT_W-1:0] val);
        return !halt && (val > CNT_W'(1));
    endfunction

endpackage

// File: rtl/twostage_wdt_prescale.sv
module twostage_wdt_prescale #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/twostage_wdt_core.sv
module twostage_wdt_core
    import twostage_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             halt,
    input  logic             smi_enable,
    input  logic             strap_hold,
    input  logic             no_reboot,
    output logic             expire,
    output logic             second,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             smi_req,
    output logic             reboot_req
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [1:0]       tos_q;
    logic             smi_q;
    logic             reboot_q;

    assign expire  = run_q && tick && !halt && !start && (cnt_q <= CNT_W'(1));
    assign second  = expire && (tos_q == 2'd1);
    assign running = run_q;
    assign cnt     = cnt_q;
    assign smi_req = smi_q;
    assign reboot_req = reboot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            run_q    <= 1'b0;
            tos_q    <= 2'd0;
            smi_q    <= 1'b0;
            reboot_q <= 1'b0;
        end else begin
            smi_q <= 1'b0;
            if (start) begin
                cnt_q <= tmr_cnt;
                run_q <= 1'b1;
                tos_q <= 2'd0;
            end else if (expire) begin
                cnt_q <= tmr_cnt;
                smi_q <= smi_enable;
                if (tos_q != 2'd3)
                    tos_q <= tos_q + 2'd1;
                if (second && !strap_hold && !no_reboot)
                    reboot_q <= 1'b1;
            end else if (run_q && tick && !halt) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/twostage_wdt_regs.sv
module twostage_wdt_regs
    import twostage_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic             expire,
    input  logic             second,
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    output logic             start,
    output logic [CNT_W-1:0] tmr_cnt,
    output logic             halt,
    output logic             lock,
    output logic             boot,
    output logic [15:0]      rdata
);
    logic [1:0]  be      [NREG];
    logic [15:0] plain_q [NREG];
    logic [7:0]  lane_lo;
    logic [7:0]  lane_hi;
    logic [15:0] sts1_q, sts2_q, cnt1_q, rld_q;
    logic [15:0] cnt1_new, sts1_wr, sts2_wr, word_rd;
    logic        wr_rld, wr_din, wr_dout, wr_cnt1;

    assign lane_lo = req.wdata[7:0];
    assign lane_hi = req.word ? req.wdata[15:8] : req.wdata[7:0];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign be[g] = lanes(req, g);
        if (is_plain(g)) begin : g_plain
            logic [15:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= plain_default(g);
                else if (|be[g])
                    q <= merge16(q, be[g], lane_lo, lane_hi) & plain_mask(g);
            end
            assign plain_q[g] = q;
        end else begin : g_none
            assign plain_q[g] = 16'h0000;
        end
    end

    assign wr_rld  = |be[W_RLD];
    assign wr_din  = be[W_DATA][0];
    assign wr_dout = be[W_DATA][1];
    assign wr_cnt1 = |be[W_CNT1];

    assign tmr_cnt  = plain_q[W_TMR][CNT_W-1:0];
    assign cnt1_new = (merge16(cnt1_q, be[W_CNT1], lane_lo, lane_hi) & CNT1_MASK)
                    | (cnt1_q & (16'h1 << C1_LOCK));
    assign sts1_wr  = merge16(sts1_q, be[W_STS1], lane_lo, lane_hi) & STS1_MASK;
    assign sts2_wr  = merge16(sts2_q, be[W_STS2], lane_lo, lane_hi) & STS2_MASK;

    assign start = (wr_rld  && can_start(cnt1_q[C1_HALT], tmr_cnt)) ||
                   (wr_cnt1 && can_start(cnt1_new[C1_HALT], tmr_cnt));

    assign halt = cnt1_q[C1_HALT];
    assign lock = cnt1_q[C1_LOCK];
    assign boot = sts2_q[S2_BOOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            sts1_q <= 16'h0000;
            sts2_q <= 16'h0000;
            cnt1_q <= 16'h0000;
            rld_q  <= 16'h0000;
        end else begin
            sts1_q <= sts1_wr | (16'(expire)  << S1_TIMEOUT)
                              | (16'(wr_din)  << S1_SWSMI)
                              | (16'(wr_dout) << S1_INT);
            sts2_q <= sts2_wr | (16'(second) << S2_SECOND)
                              | (16'(second) << S2_BOOT);
            if (wr_cnt1)
                cnt1_q <= cnt1_new;
            if (start)
                rld_q <= plain_q[W_TMR];
        end
    end

    always_comb begin
        case (int'(req.addr[ADDR_W-1:1]))
            W_RLD:   word_rd = running ? {rld_q[15:CNT_W], cnt} : rld_q;
            W_STS1:  word_rd = sts1_q;
            W_STS2:  word_rd = sts2_q;
            W_CNT1:  word_rd = cnt1_q;
            default: word_rd = plain_q[int'(req.addr[ADDR_W-1:1]) % NREG] &
                               ((int'(req.addr[ADDR_W-1:1]) < NREG) ? 16'hFFFF : 16'h0000);
        endcase
        if (req.word)
            rdata = word_rd;
        else
            rdata = {8'h00, req.addr[0] ? word_rd[15:8] : word_rd[7:0]};
    end
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
    import twostage_wdt_pkg::*;
#(
    parameter int TICK_DIV = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic              acc_word,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [15:0]       acc_wdata,
    output logic [15:0]       acc_rdata,
    input  logic              smi_enable,
    input  logic              strap_hold,
    input  logic              no_reboot,
    output logic              smi_req,
    output logic              reboot_req
);
    bus_req_t         req_w;
    logic             tick_w, start_w, halt_w, lock_w, boot_w;
    logic             expire_w, second_w, running_w;
    logic [CNT_W-1:0] tmr_cnt_w, cnt_w;

    assign req_w = '{valid: acc_en, write: acc_we, word: acc_word,
                     addr: acc_addr, wdata: acc_wdata};

    twostage_wdt_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst(rst), .restart(start_w), .tick(tick_w)
    );

    twostage_wdt_core u_core (
        .clk(clk), .rst(rst), .tick(tick_w), .start(start_w),
        .tmr_cnt(tmr_cnt_w), .halt(halt_w), .smi_enable(smi_enable),
        .strap_hold(strap_hold), .no_reboot(no_reboot),
        .expire(expire_w), .second(second_w), .running(running_w),
        .cnt(cnt_w), .smi_req(smi_req), .reboot_req(reboot_req)
    );

    twostage_wdt_regs u_regs (
        .clk(clk), .rst(rst), .req(req_w), .expire(expire_w),
        .second(second_w), .running(running_w), .cnt(cnt_w),
        .start(start_w), .tmr_cnt(tmr_cnt_w), .halt(halt_w),
        .lock(lock_w), .boot(boot_w), .rdata(acc_rdata)
    );
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk
    import twostage_wdt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             smi_enable,
    input logic             strap_hold,
    input logic             no_reboot,
    input logic             smi_req,
    input logic             reboot_req,
    input logic             start,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic [CNT_W-1:0] cnt,
    input logic             lock,
    input logic             boot
);
    a_r5_reboot_sticky: assert property (@(posedge clk) disable iff (rst)
        reboot_req |=> reboot_req);

    a_r6_reboot_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(reboot_req) |-> $past(!strap_hold && !no_reboot));

    a_r5_boot_with_reboot: assert property (@(posedge clk) disable iff (rst)
        $rose(reboot_req) |-> boot);

    a_r4_smi_enabled: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(smi_enable));

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == $past(tmr_cnt)));
endmodule

bind twostage_wdt twostage_wdt_chk u_chk (
    .clk(clk), .rst(rst), .smi_enable(smi_enable), .strap_hold(strap_hold),
    .no_reboot(no_reboot), .smi_req(smi_req), .reboot_req(reboot_req),
    .start(start_w), .tmr_cnt(tmr_cnt_w), .cnt(cnt_w), .lock(lock_w),
    .boot(boot_w)
);

// File: tb/twostage_wdt_test.sv
module twostage_wdt_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0, acc_we = 1'b0, acc_word = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        smi_enable = 1'b0, strap_hold = 1'b0, no_reboot = 1'b0;
    logic        smi_req, reboot_req;

    int checks = 0;
    int errors = 0;
    logic [15:0] rv, hold;
    logic [15:0] model [16];

    always #10 clk = ~clk;

    twostage_wdt #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
        .acc_word(acc_word), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .smi_enable(smi_enable),
        .strap_hold(strap_hold), .no_reboot(no_reboot),
        .smi_req(smi_req), .reboot_req(reboot_req)
    );

    function automatic logic [15:0] dflt(int a);
        case (a)
            16'h0A:  return 16'h0008;
            16'h10:  return 16'h0003;
            16'h12:  return 16'h0004;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic exp_reboot(logic s, logic n);
        return !s && !n;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_word = w; acc_addr = a; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic w, output logic [15:0] d);
        acc_en = 1'b1; acc_we = 1'b0; acc_word = w; acc_addr = a;
        #1;
        d = acc_rdata;
        acc_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        do_reset();

        // R1: reset values
        for (int a = 0; a < 20; a += 2) begin
            rd(5'(a), 1'b1, rv);
            check(rv == dflt(a), "R1 reset value", rv, dflt(a));
        end
        check(smi_req == 1'b0 && reboot_req == 1'b0, "R1 outputs idle",
              {14'h0, smi_req, reboot_req}, 16'h0);

        // R10: write masks and byte lanes
        wr(5'h04, 1'b1, 16'hFFFF); rd(5'h04, 1'b1, rv);
        check(rv == 16'h000E, "R10 status-1 mask", rv, 16'h000E);
        wr(5'h06, 1'b1, 16'hFFFF); rd(5'h06, 1'b1, rv);
        check(rv == 16'h0006, "R10 status-2 mask", rv, 16'h0006);
        wr(5'h04, 1'b1, 16'h0000); wr(5'h06, 1'b1, 16'h0000);
        wr(5'h0E, 1'b1, 16'hABCD); rd(5'h0E, 1'b1, rv);
        check(rv == 16'h00CD, "R10 watchdog-count 8 bits", rv, 16'h00CD);
        wr(5'h0D, 1'b0, 16'h005A); wr(5'h0C, 1'b0, 16'h0033); rd(5'h0C, 1'b1, rv);
        check(rv == 16'h5A33, "R10 odd byte is upper", rv, 16'h5A33);
        rd(5'h0D, 1'b0, rv);
        check(rv == 16'h005A, "R10 odd byte read", rv, 16'h005A);

        // R9: mailbox bytes set status flags
        wr(5'h02, 1'b0, 16'h0011); rd(5'h04, 1'b1, rv);
        check(rv == 16'h0002, "R9 data-in sets bit1", rv, 16'h0002);
        wr(5'h04, 1'b1, 16'h0000);
        wr(5'h03, 1'b0, 16'h0022); rd(5'h04, 1'b1, rv);
        check(rv == 16'h0004, "R9 data-out sets bit2", rv, 16'h0004);
        rd(5'h02, 1'b1, rv);
        check(rv == 16'h2211, "R9 mailbox data kept", rv, 16'h2211);
        wr(5'h04, 1'b1, 16'h0000);

        // R10: random storage of plain registers against a model
        for (int i = 0; i < 16; i++) model[i] = dflt(i * 2);
        model[5'h0C >> 1] = 16'h5A33;
        model[5'h0E >> 1] = 16'h00CD;
        for (int i = 0; i < 24; i++) begin
            int idx;
            logic w;
            logic [4:0] a;
            logic [15:0] d, m;
            idx = 5 + int'($urandom % 4);
            w = 1'($urandom);
            d = 16'($urandom);
            a = 5'(idx * 2) | (w ? 5'd0 : 5'($urandom % 2));
            m = (idx == 7 || idx == 8) ? 16'h00FF : 16'hFFFF;
            if (w) model[idx] = d & m;
            else if (a[0]) model[idx] = {d[7:0], model[idx][7:0]} & m;
            else model[idx] = {model[idx][15:8], d[7:0]} & m;
            wr(a, w, d);
            rd(5'(idx * 2), 1'b1, rv);
            check(rv == model[idx], "R10 random storage", rv, model[idx]);
        end

        // R2: values 0 and 1 never start
        wr(5'h12, 1'b1, 16'h0001); wr(5'h00, 1'b1, 16'h0000);
        wr(5'h12, 1'b1, 16'h0000); wr(5'h00, 1'b1, 16'h0000);
        wait_cyc(40);
        rd(5'h04, 1'b1, rv);
        check(rv[3] == 1'b0, "R2 no start for 0/1", rv, 16'h0000);
        rd(5'h00, 1'b1, rv);
        check(rv == 16'h0000, "R2 reload stays idle", rv, 16'h0000);

        // R8, R3, R4, R6: no_reboot blocks, SMI enabled
        smi_enable = 1'b1; no_reboot = 1'b1; strap_hold = 1'b0;
        wr(5'h12, 1'b1, 16'hA406);
        wr(5'h00, 1'b1, 16'h0000);
        rd(5'h00, 1'b1, rv);
        check(rv == 16'hA406, "R8 readback at start", rv, 16'hA406);
        wait_cyc(DIV);
        rd(5'h00, 1'b1, rv);
        check(rv == 16'hA405, "R8 remaining ticks", rv, 16'hA405);
        wait_cyc(6 * DIV - 1 - DIV);
        rd(5'h04, 1'b1, rv);
        check(rv[3] == 1'b0, "R3 not yet expired", rv, 16'h0000);
        wait_cyc(1);
        rd(5'h04, 1'b1, rv);
        check(rv[3] == 1'b1, "R3 first expiry", rv, 16'h0008);
        check(smi_req == 1'b1, "R4 SMI pulse", 16'(smi_req), 16'h1);
        wait_cyc(1);
        check(smi_req == 1'b0, "R4 SMI one cycle", 16'(smi_req), 16'h0);
        wait_cyc(6 * DIV - 2);
        rd(5'h06, 1'b1, rv);
        check(rv == 16'h0000, "R3 second not yet", rv, 16'h0000);
        wait_cyc(1);
        rd(5'h06, 1'b1, rv);
        check(rv == 16'h0006, "R6 status-2 still set", rv, 16'h0006);
        check(reboot_req == 1'b0, "R6 no_reboot blocks", 16'(reboot_req), 16'h0);

        // R11, R5: reload clears the expiry count
        do_reset();
        smi_enable = 1'b0; no_reboot = 1'b0; strap_hold = 1'b0;
        wr(5'h12, 1'b1, 16'h0003);
        wr(5'h00, 1'b1, 16'h0000);
        wait_cyc(3 * DIV);
        rd(5'h04, 1'b1, rv);
        check(rv[3] == 1'b1, "R3 expiry N=3", rv, 16'h0008);
        check(smi_req == 1'b0, "R4 no SMI when disabled", 16'(smi_req), 16'h0);
        wr(5'h00, 1'b1, 16'h0000);
        wait_cyc(3 * DIV);
        rd(5'h06, 1'b1, rv);
        check(rv == 16'h0000, "R11 reload clears count", rv, 16'h0000);
        check(reboot_req == 1'b0, "R11 no reboot", 16'(reboot_req), 16'h0);
        wait_cyc(3 * DIV);
        rd(5'h06, 1'b1, rv);
        check(rv == 16'h0006, "R5 status-2 bits", rv, 16'h0006);
        check(reboot_req == 1'b1, "R5 reboot asserted", 16'(reboot_req), 16'h1);
        wr(5'h06, 1'b1, 16'h0000);
        wr(5'h00, 1'b1, 16'h0000);
        wait_cyc(50);
        check(reboot_req == 1'b1, "R5 reboot sticky", 16'(reboot_req), 16'h1);

        // R7: lock, halt, restart through control-1
        do_reset();
        wr(5'h12, 1'b1, 16'h0014);
        wr(5'h08, 1'b1, 16'h1000);
        rd(5'h08, 1'b1, rv);
        check(rv == 16'h1000, "R7 lock set", rv, 16'h1000);
        rd(5'h00, 1'b1, rv);
        check(rv == 16'h0014, "R7 control-1 write starts", rv, 16'h0014);
        wait_cyc(DIV);
        wr(5'h08, 1'b1, 16'h0800);
        rd(5'h08, 1'b1, rv);
        check(rv == 16'h1800, "R7 halt with lock kept", rv, 16'h1800);
        rd(5'h00, 1'b1, hold);
        wait_cyc(20);
        rd(5'h00, 1'b1, rv);
        check(rv == hold, "R7 halt freezes count", rv, hold);
        wr(5'h00, 1'b1, 16'h0000);
        rd(5'h00, 1'b1, rv);
        check(rv == hold, "R2 halt blocks reload start", rv, hold);
        wr(5'h08, 1'b1, 16'h0000);
        rd(5'h08, 1'b1, rv);
        check(rv == 16'h1000, "R7 lock not cleared", rv, 16'h1000);
        rd(5'h00, 1'b1, rv);
        check(rv == 16'h0014, "R7 unhalt restarts", rv, 16'h0014);

        // R3, R4, R5, R6: random runs
        for (int i = 0; i < 12; i++) begin
            int n;
            logic exp_r;
            do_reset();
            n = 2 + int'($urandom % 8);
            smi_enable = 1'($urandom);
            strap_hold = 1'($urandom);
            no_reboot  = 1'($urandom);
            exp_r = exp_reboot(strap_hold, no_reboot);
            wr(5'h12, 1'b1, 16'(n));
            wr(5'h00, 1'b1, 16'h0000);
            wait_cyc(n * DIV - 1);
            rd(5'h04, 1'b1, rv);
            check(rv[3] == 1'b0, "R3 random before expiry", rv, 16'h0000);
            wait_cyc(1);
            rd(5'h04, 1'b1, rv);
            check(rv[3] == 1'b1, "R3 random expiry", rv, 16'h0008);
            check(smi_req == smi_enable, "R4 random SMI", 16'(smi_req), 16'(smi_enable));
            wait_cyc(n * DIV);
            rd(5'h06, 1'b1, rv);
            check(rv == 16'h0006, "R5 random status-2", rv, 16'h0006);
            check(reboot_req == exp_r, "R6 random reboot gate",
                  16'(reboot_req), 16'(exp_r));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule